// File: doc/BRIEF.md
# Delayed-Update LMS Adaptive Echo Canceller

This block removes a linear echo of a far-end signal from a near-end signal. Each accepted sample pair carries a reference (far-end) sample and a desired (near-end, echo-corrupted) sample. The block runs them through a finite impulse response filter whose taps model the echo path. It returns the echo estimate and the cancelled signal, which is the error. The taps adapt by the least-mean-squares rule. The step size is a power of two, so the update is an arithmetic right shift and needs no multiplier for the step.

Only one multiply-accumulate engine exists. It visits one tap per clock: it adds that tap's product to the estimate and rewrites the same tap in the same cycle. For this to work, the tap update uses the error from two samples earlier together with the reference sample that was aligned with that error, which is the delayed-update form of the rule. Every tap is still updated once per sample, and each accepted sample gives exactly one result.

Numbers are two's complement. Samples and the error are 16 bits. A coefficient is 24 bits and is read as a fraction with 23 fractional bits, and only its upper 16 bits enter the products. The accumulator is 40 bits. The host gives the step exponent together with each sample.

Top module: `lms_echo_canceller`

## Requirements
- R1: After reset the block has in_ready = 1, out_valid = 0, echo_est = 0 and err_out = 0, and all coefficients and all history are zero.
- R2: A sample is taken only in a cycle where in_valid and in_ready are both high. From the edge that takes it, in_ready stays low for TAPS+1 cycles. A pulse on in_valid while in_ready is low is ignored and changes no later result.
- R3: out_valid is high for one cycle, TAPS+1 clock edges after the edge that takes the sample. in_ready returns high in that same cycle, so a new sample can be taken every TAPS+2 clocks.
- R4: With w_k the coefficients held at the start of sample n, hi(w) = w >>> 8 (the upper 16 bits) and x(n-k) the reference history (zero before the first sample), the estimate is y(n) = floor(sum over k of hi(w_k)·x(n-k) / 2^15), saturated to [-32768, 32767].
- R5: err_out = d(n) − y(n), saturated to [-32768, 32767]. The saturated value is also the one stored for adaptation.
- R6: During sample n, every tap is updated once. The update is w_k += q(e(n-2)·x(n-2-k), 7+s), where s is the step exponent taken with sample n and the result is saturated to the 24-bit range. Errors from before the first sample count as zero.
- R7: q(p, m) divides p by 2^m and rounds toward zero, so a product of −64 with m = 7 adds 0 rather than −1.
- R8: The step exponent s (0 to 15) is taken together with the sample, and a larger s gives a proportionally smaller tap change.
- R9: A one-cycle clr zeroes all coefficients, the reference history and the error history, and returns the block to idle. A sample offered in the same cycle as clr is not taken.
- R10: When the echo path fits within the tap span, the error power over late samples falls well below its value over the first samples.
- R11: An error is first used in the update two samples after it is produced. With empty history, the estimates of the first three samples are zero, and the error of sample 0 first shows up in the estimate of sample 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of coefficients and history |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Block idle and able to take a sample |
| ref_in | input | 16 | Far-end reference sample |
| near_in | input | 16 | Near-end desired sample containing echo |
| mu_shift | input | 4 | Step exponent s for this sample |
| out_valid | output | 1 | One-cycle strobe: results are valid |
| echo_est | output | 16 | Echo estimate y(n) |
| err_out | output | 16 | Cancelled signal e(n) |

## Verification
The result of a sample is due TAPS+1 rising edges after the edge that took it: one edge per tap, plus one edge that registers the saturated estimate and error. The bench drives and samples on falling edges and counts them from the taking edge. It expects in_ready low on every falling edge up to the one where out_valid first appears, which is the TAPS+2nd. It reads the estimate and error only on that falling edge. Because the error is used two samples late, the hand-computed vectors put the first effect of a sample-0 error into the sample-3 estimate. The longer run compares every result with a model that holds the same two-sample error delay.

// File: rtl/lms_pkg.sv
package lms_pkg;

    localparam int SAMPLE_W = 16;
    localparam int COEF_W   = 24;
    localparam int ACC_W    = 40;
    localparam int PROD_W   = 2 * SAMPLE_W;
    // product of two Q15 values is Q30; a coefficient is Q23
    localparam int FRAC_SH  = SAMPLE_W - 1;
    localparam int UPD_SH   = 2 * (SAMPLE_W - 1) - (COEF_W - 1);

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0]   coef_t;
    typedef logic signed [COEF_W+1:0]   csum_t;
    typedef logic signed [ACC_W-1:0]    acc_t;
    typedef logic signed [PROD_W-1:0]   prod_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_RUN,
        SEQ_FIN
    } seq_state_e;

    // reference pair seen by the engine for one tap
    typedef struct packed {
        sample_t cur;   // x(n-k), used by the estimate
        sample_t aged;  // x(n-LAG-k), used by the update
    } tap_ref_t;

    typedef struct packed {
        sample_t est;
        sample_t err;
    } result_t;

    function automatic prod_t mul_s(input sample_t a, input sample_t b);
        return prod_t'(a) * prod_t'(b);
    endfunction

    function automatic sample_t clip_sample(input acc_t v);
        acc_t hi;
        acc_t lo;
        hi = acc_t'((2 ** (SAMPLE_W - 1)) - 1);
        lo = -hi - acc_t'(1);
        if (v > hi)
            return sample_t'(hi);
        else if (v < lo)
            return sample_t'(lo);
        else
            return sample_t'(v);
    endfunction

    function automatic coef_t clip_coef(input csum_t v);
        csum_t hi;
        csum_t lo;
        hi = csum_t'((2 ** (COEF_W - 1)) - 1);
        lo = -hi - csum_t'(1);
        if (v > hi)
            return coef_t'(hi);
        else if (v < lo)
            return coef_t'(lo);
        else
            return coef_t'(v);
    endfunction

    // divide by 2^sh, rounding toward zero
    function automatic prod_t shift_to_zero(input prod_t p, input logic [5:0] sh);
        prod_t mag;
        mag = p[PROD_W-1] ? -p : p;
        mag = mag >>> sh;
        return p[PROD_W-1] ? -mag : mag;
    endfunction

endpackage

// File: rtl/lms_tap_sequencer.sv
module lms_tap_sequencer
    import lms_pkg::*;
#(
    parameter int TAPS  = 128,
    parameter int IDX_W = $clog2(TAPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             accept,
    output logic             run_en,
    output logic             fin,
    output logic [IDX_W-1:0] tap_idx
);

    seq_state_e       state;
    logic [IDX_W-1:0] idx;
    logic             last;

    assign in_ready = (state == SEQ_IDLE);
    assign accept   = in_valid && in_ready && !clr;
    assign run_en   = (state == SEQ_RUN);
    assign fin      = (state == SEQ_FIN);
    assign tap_idx  = idx;
    assign last     = (idx == IDX_W'(TAPS - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state <= SEQ_IDLE;
            idx   <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (accept) begin
                        state <= SEQ_RUN;
                        idx   <= '0;
                    end
                end
                SEQ_RUN: begin
                    if (last) begin
                        state <= SEQ_FIN;
                        idx   <= '0;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
                SEQ_FIN: state <= SEQ_IDLE;
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // R2: a taken sample closes the input on the next cycle
    assert_accept_drops_ready_R2: assert property (@(posedge clk) disable iff (rst)
        accept |=> !in_ready);

    // R3: one tap per clock, no skipped or repeated tap
    assert_tap_step_R3: assert property (@(posedge clk) disable iff (rst)
        (run_en && !last && !clr) |=> (tap_idx == $past(tap_idx) + IDX_W'(1)));

endmodule

// File: rtl/lms_ref_line.sv
module lms_ref_line
    import lms_pkg::*;
#(
    parameter int TAPS   = 128,
    parameter int LAG    = 2,
    parameter int IDX_W  = $clog2(TAPS),
    parameter int DEPTH  = TAPS + LAG,
    parameter int DIDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  sample_t          x_in,
    input  logic [IDX_W-1:0] tap_idx,
    output tap_ref_t         taps
);

    sample_t           hist [DEPTH];
    logic [DIDX_W-1:0] cur_i;
    logic [DIDX_W-1:0] old_i;

    assign cur_i     = DIDX_W'(tap_idx);
    assign old_i     = DIDX_W'(tap_idx) + DIDX_W'(LAG);
    assign taps.cur  = hist[cur_i];
    assign taps.aged = hist[old_i];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < DEPTH; i++)
                hist[i] <= '0;
        end else if (push) begin
            hist[0] <= x_in;
            for (int i = 1; i < DEPTH; i++)
                hist[i] <= hist[i-1];
        end
    end

endmodule

// File: rtl/lms_coef_bank.sv
module lms_coef_bank
    import lms_pkg::*;
#(
    parameter int TAPS    = 128,
    parameter int SHIFT_W = 4,
    parameter int IDX_W   = $clog2(TAPS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               accept,
    input  logic [SHIFT_W-1:0] mu_in,
    input  logic               upd_en,
    input  logic [IDX_W-1:0]   tap_idx,
    input  sample_t            x_aged,
    input  sample_t            err_lag,
    output sample_t            w_hi
);

    coef_t              w [TAPS];
    logic [SHIFT_W-1:0] mu_q;
    coef_t              w_rd;
    prod_t              delta;
    coef_t              w_new;
    logic [5:0]         sh_amt;

    assign w_rd   = w[tap_idx];
    assign w_hi   = w_rd[COEF_W-1 -: SAMPLE_W];
    assign sh_amt = 6'(UPD_SH) + 6'(mu_q);
    assign delta  = shift_to_zero(mul_s(x_aged, err_lag), sh_amt);
    assign w_new  = clip_coef(csum_t'(w_rd) + csum_t'(delta));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            mu_q <= '0;
            for (int i = 0; i < TAPS; i++)
                w[i] <= '0;
        end else begin
            if (accept)
                mu_q <= mu_in;
            if (upd_en)
                w[tap_idx] <= w_new;
        end
    end

    // R9: after a clear the engine is parked on a zeroed tap
    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> (w_hi == '0));

endmodule

// File: rtl/lms_mac_err.sv
module lms_mac_err
    import lms_pkg::*;
#(
    parameter int LAG = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    accept,
    input  sample_t d_in,
    input  logic    run_en,
    input  logic    fin,
    input  sample_t x_cur,
    input  sample_t w_hi,
    output result_t res,
    output logic    out_valid,
    output sample_t err_lag
);

    acc_t    acc;
    sample_t d_q;
    sample_t eh [LAG];
    sample_t est_c;
    sample_t err_c;

    assign est_c   = clip_sample(acc >>> FRAC_SH);
    assign err_c   = clip_sample(acc_t'(d_q) - acc_t'(est_c));
    assign err_lag = eh[LAG-1];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc       <= '0;
            d_q       <= '0;
            res       <= '0;
            out_valid <= 1'b0;
            for (int i = 0; i < LAG; i++)
                eh[i] <= '0;
        end else begin
            out_valid <= fin;
            if (accept) begin
                acc <= '0;
                d_q <= d_in;
            end else if (run_en) begin
                acc <= acc + acc_t'(mul_s(w_hi, x_cur));
            end
            if (fin) begin
                res   <= '{est: est_c, err: err_c};
                eh[0] <= err_c;
                for (int i = 1; i < LAG; i++)
                    eh[i] <= eh[i-1];
            end
        end
    end

    // R3: the result strobe lasts exactly one cycle
    assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

endmodule

// File: rtl/lms_echo_canceller.sv
module lms_echo_canceller
    import lms_pkg::*;
#(
    parameter int TAPS    = 128,
    parameter int LAG     = 2,
    parameter int SHIFT_W = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic signed [SAMPLE_W-1:0] ref_in,
    input  logic signed [SAMPLE_W-1:0] near_in,
    input  logic [SHIFT_W-1:0]         mu_shift,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] echo_est,
    output logic signed [SAMPLE_W-1:0] err_out
);

    localparam int IDX_W = $clog2(TAPS);

    logic             accept;
    logic             run_en;
    logic             fin;
    logic [IDX_W-1:0] tap_idx;
    tap_ref_t         taps;
    sample_t          w_hi;
    sample_t          err_lag;
    result_t          res;

    lms_tap_sequencer #(.TAPS(TAPS), .IDX_W(IDX_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .accept   (accept),
        .run_en   (run_en),
        .fin      (fin),
        .tap_idx  (tap_idx)
    );

    lms_ref_line #(.TAPS(TAPS), .LAG(LAG), .IDX_W(IDX_W)) u_ref (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .push    (accept),
        .x_in    (ref_in),
        .tap_idx (tap_idx),
        .taps    (taps)
    );

    lms_coef_bank #(.TAPS(TAPS), .SHIFT_W(SHIFT_W), .IDX_W(IDX_W)) u_coef (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .accept  (accept),
        .mu_in   (mu_shift),
        .upd_en  (run_en),
        .tap_idx (tap_idx),
        .x_aged  (taps.aged),
        .err_lag (err_lag),
        .w_hi    (w_hi)
    );

    lms_mac_err #(.LAG(LAG)) u_mac (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .accept    (accept),
        .d_in      (near_in),
        .run_en    (run_en),
        .fin       (fin),
        .x_cur     (taps.cur),
        .w_hi      (w_hi),
        .res       (res),
        .out_valid (out_valid),
        .err_lag   (err_lag)
    );

    assign echo_est = res.est;
    assign err_out  = res.err;

    // R3: the input reopens in the cycle the result appears
    assert_ready_with_result_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> in_ready);

endmodule

// File: tb/lms_echo_canceller_tb_top.sv
module lms_echo_canceller_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TAPS       = 128;
    localparam int LAG        = 2;
    localparam int WATCHDOG   = 190000;
    localparam int RUN_LEN    = 600;
    localparam int WIN        = 64;

    // baseline vectors: {x, d, s, expected est, expected err}
    localparam int VEC [4][5] = '{
        '{16384, 8192, 0,    0,  8192},
        '{    0,    0, 0,    0,     0},
        '{    0,    0, 0,    0,     0},
        '{ 8192,    0, 0, 1024, -1024}
    };

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               clr = 1'b0;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic signed [15:0] ref_in = '0;
    logic signed [15:0] near_in = '0;
    logic [3:0]         mu_shift = '0;
    logic               out_valid;
    logic signed [15:0] echo_est;
    logic signed [15:0] err_out;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    int mw [TAPS];
    int mx [TAPS+LAG];
    int me [LAG];

    always #(CLK_PERIOD/2) clk = ~clk;

    lms_echo_canceller #(.TAPS(TAPS), .LAG(LAG), .SHIFT_W(4)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .ref_in    (ref_in),
        .near_in   (near_in),
        .mu_shift  (mu_shift),
        .out_valid (out_valid),
        .echo_est  (echo_est),
        .err_out   (err_out)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int sat_to(input longint v, input longint lim);
        if (v > lim - 1) return int'(lim - 1);
        if (v < -lim)    return int'(-lim);
        return int'(v);
    endfunction

    task automatic model_clear();
        for (int k = 0; k < TAPS; k++) mw[k] = 0;
        for (int k = 0; k < TAPS + LAG; k++) mx[k] = 0;
        for (int k = 0; k < LAG; k++) me[k] = 0;
    endtask

    task automatic model_step(input int x, input int d, input int s,
                              output int est, output int err);
        longint acc;
        longint p;
        longint dl;
        int     sh;
        for (int k = TAPS + LAG - 1; k > 0; k--) mx[k] = mx[k-1];
        mx[0] = x;
        acc = 0;
        for (int k = 0; k < TAPS; k++)
            acc += longint'(mw[k] >>> 8) * longint'(mx[k]);
        est = sat_to(acc >>> 15, 32768);
        err = sat_to(longint'(d) - longint'(est), 32768);
        sh = 7 + s;
        for (int k = 0; k < TAPS; k++) begin
            p  = longint'(me[LAG-1]) * longint'(mx[k+LAG]);
            dl = (p < 0) ? -((-p) >>> sh) : (p >>> sh);
            mw[k] = sat_to(longint'(mw[k]) + dl, 64'sd8388608);
        end
        for (int k = LAG - 1; k > 0; k--) me[k] = me[k-1];
        me[0] = err;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    // offer one sample, follow it to its result and check handshake timing
    task automatic run_sample(input int x, input int d, input int s, input bit inject,
                              output int est, output int err);
        int cnt;
        bit ready_ok;
        while (!in_ready) @(negedge clk);
        ref_in   = 16'(x);
        near_in  = 16'(d);
        mu_shift = 4'(s);
        in_valid = 1'b1;
        @(negedge clk);
        cnt      = 1;
        in_valid = 1'b0;
        ready_ok = 1'b1;
        while (!out_valid && cnt < TAPS + 10) begin
            if (in_ready) ready_ok = 1'b0;
            // R2: a stray offer while busy must be ignored
            in_valid = inject && (cnt == 5);
            if (in_valid) ref_in = 16'sh7000;
            @(negedge clk);
            cnt++;
        end
        in_valid = 1'b0;
        check(ready_ok, "R2", "in_ready low while busy", int'(ready_ok), 1);
        check(cnt == TAPS + 2, "R3", "falling edges to result", cnt, TAPS + 2);
        check(in_ready, "R3", "in_ready back with result", int'(in_ready), 1);
        est = int'(echo_est);
        err = int'(err_out);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R3 watchdog: actual %0d cycles expected fewer", WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int e;
        int r;
        int me_v;
        int mr_v;
        int lcg;
        int xs [4];
        int x;
        int d;
        longint early;
        longint late;
        logic signed [15:0] rnd;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(echo_est == 16'sd0, "R1", "echo_est after reset", int'(echo_est), 0);
        check(err_out == 16'sd0, "R1", "err_out after reset", int'(err_out), 0);

        // R11 baseline table: two-sample error delay
        for (int i = 0; i < 4; i++) begin
            run_sample(VEC[i][0], VEC[i][1], VEC[i][2], 1'b0, e, r);
            check(e == VEC[i][3], "R11", $sformatf("table %0d estimate", i), e, VEC[i][3]);
            check(r == VEC[i][4], "R11", $sformatf("table %0d error", i), r, VEC[i][4]);
        end

        // R8 step exponent 3 scales the tap change by 1/8
        pulse_clear();
        run_sample(16384, 8192, 3, 1'b0, e, r);
        run_sample(0, 0, 3, 1'b0, e, r);
        run_sample(0, 0, 3, 1'b0, e, r);
        run_sample(8192, 0, 3, 1'b0, e, r);
        check(e == 128, "R8", "estimate with shift 3", e, 128);
        check(r == -128, "R8", "error with shift 3", r, -128);

        // R7 rounding toward zero of a -0.5 tap step
        pulse_clear();
        run_sample(64, -1, 0, 1'b0, e, r);
        check(r == -1, "R5", "error of lone sample", r, -1);
        run_sample(0, 0, 0, 1'b0, e, r);
        run_sample(0, 0, 0, 1'b0, e, r);
        run_sample(32767, 0, 0, 1'b0, e, r);
        check(e == 0, "R7", "estimate after -0.5 step", e, 0);

        // R5 error saturation, R4 negative estimate
        pulse_clear();
        run_sample(16384, 8192, 0, 1'b0, e, r);
        run_sample(0, 0, 0, 1'b0, e, r);
        run_sample(0, 0, 0, 1'b0, e, r);
        run_sample(-8192, 32767, 0, 1'b0, e, r);
        check(e == -1024, "R4", "negative estimate", e, -1024);
        check(r == 32767, "R5", "saturated error", r, 32767);

        // R9 clear with a same-cycle offer: offer dropped, taps zeroed
        @(negedge clk);
        clr      = 1'b1;
        in_valid = 1'b1;
        ref_in   = 16'sd30000;
        @(negedge clk);
        check(in_ready == 1'b1, "R9", "offer during clear not taken", int'(in_ready), 1);
        clr      = 1'b0;
        in_valid = 1'b0;
        run_sample(8192, 0, 0, 1'b0, e, r);
        check(e == 0, "R9", "estimate after clear", e, 0);
        check(r == 0, "R9", "error after clear", r, 0);

        // R6 / R10 long adaptive run against the model
        pulse_clear();
        model_clear();
        lcg   = 32'h1234_5678;
        early = 0;
        late  = 0;
        for (int k = 0; k < 4; k++) xs[k] = 0;
        for (int n = 0; n < RUN_LEN; n++) begin
            lcg = lcg * 1103515245 + 12345;
            rnd = lcg[31:16];
            x   = int'(rnd) >>> 1;
            for (int k = 3; k > 0; k--) xs[k] = xs[k-1];
            xs[0] = x;
            d = (xs[0] >>> 1) + (xs[3] >>> 2);
            run_sample(x, d, 4, n == 100, e, r);
            model_step(x, d, 4, me_v, mr_v);
            check(e == me_v, "R4", $sformatf("run %0d estimate", n), e, me_v);
            check(r == mr_v, "R6", $sformatf("run %0d error", n), r, mr_v);
            if (n < WIN) early += longint'(r) * longint'(r);
            if (n >= RUN_LEN - WIN) late += longint'(r) * longint'(r);
        end
        check(late * 8 < early, "R10", "late error energy / 1000",
              int'(late / 1000), int'(early / 8000));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule